// File: doc/BRIEF.md
# Periodic Rollover Interrupt Generator

This block turns the rollover pulses of a real-time clock's counter chain into a periodic interrupt. Each of the six time units (for example tenths of a second, seconds, minutes, hours, days and months) delivers a one-cycle pulse on its own `tick_i` bit whenever that counter increments. Software picks which units may interrupt by writing a six-bit enable mask. When an enabled unit rolls over, a pending periodic flag is set and the interrupt line goes high. The flag stays set until software writes one to clear it.

The interrupt follows the counter chain and not a separate timer. Enabling a source therefore takes effect on the very next pulse of that source, so the first interrupt can arrive before a full period has passed. Later interrupts arrive once per period. The block also handles entry into battery standby. When the standby-keep control is low at entry, the enable mask is wiped and must be written again afterwards. When it is high, the periodic interrupt keeps working through standby.

Top module: `pirq_periodic_top`

## Requirements
- R1: After reset, `enables_o` is 0, and both `flag_o` and `irq_o` are 0.
- R2: A cycle with `cfg_wr_i` high loads `cfg_wdata_i` into `enables_o`, visible after that clock edge. The exception is when a standby entry clears the mask in the same cycle (R8).
- R3: A `tick_i[k]` pulse while `enables_o[k]` is 1 sets `flag_o` after that edge. This holds for the first pulse that follows an enable write, with no wait for a full period. It also holds when the mask stays non-zero.
- R4: A `tick_i[k]` pulse while `enables_o[k]` is 0 leaves `flag_o` unchanged.
- R5: Once set, `flag_o` stays 1 through idle cycles and through further enabled pulses until a clear is written.
- R6: A cycle with `clr_wr_i` high clears `flag_o` after that edge. If an enabled pulse arrives in the same cycle, the flag stays 1, so the event is not lost.
- R7: While the enable mask is all zeros, `flag_o` and `irq_o` are 0. Any pending flag is dropped on the edge where the mask becomes zero, and pulses cannot set it.
- R8: A rising edge on `standby_i` while `standby_keep_i` is 0 clears `enables_o` to 0 at that edge, and this overrides a write in the same cycle. While `standby_keep_i` is 1, the mask is kept and enabled pulses still set the flag in standby.
- R9: `irq_o` equals `flag_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | N_SRC | One-cycle rollover pulse per time unit |
| cfg_wr_i | input | 1 | Write strobe for the enable mask |
| cfg_wdata_i | input | N_SRC | New enable mask |
| clr_wr_i | input | 1 | Write-one-to-clear strobe for the periodic flag |
| standby_i | input | 1 | High while the clock runs from the backup supply |
| standby_keep_i | input | 1 | 1: enables survive standby entry; 0: they are cleared |
| enables_o | output | N_SRC | Current enable mask |
| flag_o | output | 1 | Periodic status flag |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The assertions check several properties on every cycle. An enabled pulse is followed by a set flag. The flag holds while no clear, write or standby is present. A clear with no competing pulse empties the flag. An all-zero mask never coexists with a set flag. A standby entry without keep leaves the mask empty. Other behaviour can only be shown by the bench's scenarios: the early first interrupt right after enabling, disabled sources having no effect, the clear-versus-pulse race, and the flag still being set by pulses inside standby when keep is on.

// File: rtl/pirq_pkg.sv
// Package: shared constants and types for the periodic rollover interrupt.
// Assumes: source index order is the time-unit order of the counter chain.
package pirq_pkg;
    localparam int N_SRC_DEF = 6;
    typedef logic [N_SRC_DEF-1:0] src_mask_t;
endpackage

// File: rtl/pirq_enable_reg.sv
// Module: holds the per-source enable mask; loads it on a config write
// and wipes it on standby entry unless keep is requested.
// Assumes: standby_i is synchronous to clk; entry is its rising edge.
module pirq_enable_reg #(
    parameter int N_SRC = pirq_pkg::N_SRC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic             stby_i,
    input  logic             keep_i,
    output logic [N_SRC-1:0] en_o,
    output logic [N_SRC-1:0] en_nxt_o
);
    logic             stby_q;
    logic [N_SRC-1:0] en_q;
    logic             wipe;

    // Detect standby entry that must clear the mask.
    assign wipe = stby_i && !stby_q && !keep_i;

    // Next-state of the mask: wipe beats write, write beats hold.
    always_comb begin
        if (wipe)
            en_nxt_o = '0;
        else if (wr_i)
            en_nxt_o = wdata_i;
        else
            en_nxt_o = en_q;
    end

    // Register the mask and the previous standby level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            stby_q <= 1'b0;
        end else begin
            en_q   <= en_nxt_o;
            stby_q <= stby_i;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/pirq_event_merge.sv
// Module: masks each rollover pulse by its enable and merges them
// into one hit strobe.
// Assumes: tick pulses last one cycle.
module pirq_event_merge #(
    parameter int N_SRC = pirq_pkg::N_SRC_DEF
) (
    input  logic [N_SRC-1:0] tick_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             hit_o
);
    logic [N_SRC-1:0] masked;

    // One gate per source.
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign masked[k] = tick_i[k] & en_i[k];
    end

    // Any enabled source rolled over.
    assign hit_o = |masked;
endmodule

// File: rtl/pirq_flag.sv
// Module: sticky pending flag. A hit sets it, a write-one clears it,
// a hit beats a clear, and an empty next mask forces it low.
// Assumes: any_en_nxt_i reflects the mask valid after the same edge.
module pirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic any_en_nxt_i,
    output logic pend_o
);
    logic pend_q;

    // Update the pending flag with its set/clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (!any_en_nxt_i)
            pend_q <= 1'b0;
        else if (hit_i)
            pend_q <= 1'b1;
        else if (clr_i)
            pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pirq_periodic_top.sv
// Module: periodic rollover interrupt generator top. Ties together
// the enable mask, the event merge and the sticky flag.
// Assumes: all inputs synchronous to clk; pad drive handled outside.
module pirq_periodic_top #(
    parameter int N_SRC = pirq_pkg::N_SRC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick_i,
    input  logic             cfg_wr_i,
    input  logic [N_SRC-1:0] cfg_wdata_i,
    input  logic             clr_wr_i,
    input  logic             standby_i,
    input  logic             standby_keep_i,
    output logic [N_SRC-1:0] enables_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] en_nxt;
    logic             hit;
    logic             pend;

    pirq_enable_reg #(.N_SRC(N_SRC)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .wdata_i  (cfg_wdata_i),
        .stby_i   (standby_i),
        .keep_i   (standby_keep_i),
        .en_o     (en),
        .en_nxt_o (en_nxt)
    );

    pirq_event_merge #(.N_SRC(N_SRC)) u_merge (
        .tick_i (tick_i),
        .en_i   (en),
        .hit_o  (hit)
    );

    pirq_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .clr_i        (clr_wr_i),
        .any_en_nxt_i (|en_nxt),
        .pend_o       (pend)
    );

    // Drive the outputs.
    assign enables_o = en;
    assign flag_o    = pend;
    assign irq_o     = pend;
endmodule

// File: rtl/pirq_periodic_chk.sv
// Module: assertion checker for pirq_periodic_top, attached by bind.
// Assumes: observes top-level ports only.
module pirq_periodic_chk #(
    parameter int N_SRC = pirq_pkg::N_SRC_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] tick_i,
    input logic             cfg_wr_i,
    input logic             clr_wr_i,
    input logic             standby_i,
    input logic             standby_keep_i,
    input logic [N_SRC-1:0] enables_o,
    input logic             flag_o
);
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tick_i & enables_o)) |=> (enables_o == '0 || flag_o)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_wr_i && !cfg_wr_i && !standby_i) |=> flag_o); // R5

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !(|(tick_i & enables_o))) |=> !flag_o); // R6

    AST_EMPTY_MASK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (enables_o == '0) |-> !flag_o); // R7

    AST_STANDBY_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(standby_i) && !standby_keep_i) |=> (enables_o == '0)); // R8
endmodule

bind pirq_periodic_top pirq_periodic_chk #(.N_SRC(N_SRC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .cfg_wr_i       (cfg_wr_i),
    .clr_wr_i       (clr_wr_i),
    .standby_i      (standby_i),
    .standby_keep_i (standby_keep_i),
    .enables_o      (enables_o),
    .flag_o         (flag_o)
);

// File: tb/pirq_periodic_top_tb.sv
// Bench: directed scenarios for pirq_periodic_top, one task each.
module pirq_periodic_top_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] tick_i = '0;
    logic         cfg_wr_i = 1'b0;
    logic [N-1:0] cfg_wdata_i = '0;
    logic         clr_wr_i = 1'b0;
    logic         standby_i = 1'b0;
    logic         standby_keep_i = 1'b0;
    logic [N-1:0] enables_o;
    logic         flag_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pirq_periodic_top #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
        .cfg_wdata_i(cfg_wdata_i), .clr_wr_i(clr_wr_i), .standby_i(standby_i),
        .standby_keep_i(standby_keep_i), .enables_o(enables_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // Compare one value and record the outcome.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge, then clear single-cycle strobes at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        tick_i = '0; cfg_wr_i = 1'b0; clr_wr_i = 1'b0;
    endtask

    task automatic write_en(input logic [N-1:0] m);
        cfg_wr_i = 1'b1; cfg_wdata_i = m; step();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 enables", enables_o, 0);
        chk("R1 flag", flag_o, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_write_and_first();
        write_en(6'b000010);
        chk("R2 enables", enables_o, 2);
        tick_i = 6'b111101; step();
        chk("R4 disabled ticks", flag_o, 0);
        tick_i = 6'b000010; step();
        chk("R3 early first irq flag", flag_o, 1);
        chk("R9 irq follows flag", irq_o, 1);
    endtask

    task automatic t_hold_clear();
        step(); step(); step();
        chk("R5 hold idle", flag_o, 1);
        tick_i = 6'b000010; step();
        chk("R5 hold on retick", flag_o, 1);
        clr_wr_i = 1'b1; step();
        chk("R6 clear", flag_o, 0);
        chk("R9 irq low", irq_o, 0);
        clr_wr_i = 1'b1; tick_i = 6'b000010; step();
        chk("R6 hit beats clear", flag_o, 1);
        clr_wr_i = 1'b1; step();
        chk("R6 clear again", flag_o, 0);
    endtask

    task automatic t_mask();
        tick_i = 6'b000010; step();
        chk("R3 set before mask", flag_o, 1);
        write_en('0);
        chk("R7 flag dropped", flag_o, 0);
        chk("R7 irq dropped", irq_o, 0);
        tick_i = '1; step();
        chk("R7 ticks ignored", flag_o, 0);
    endtask

    task automatic t_standby();
        write_en('1);
        standby_keep_i = 1'b0; standby_i = 1'b1; step();
        chk("R8 wipe on entry", enables_o, 0);
        standby_i = 1'b0; step();
        write_en('1);
        standby_i = 1'b1; cfg_wr_i = 1'b1; cfg_wdata_i = 6'b000111; step();
        chk("R8 wipe beats write", enables_o, 0);
        standby_i = 1'b0; step();
        write_en('1);
        standby_keep_i = 1'b1; standby_i = 1'b1; step();
        chk("R8 keep mask", enables_o, 63);
        tick_i = 6'b100000; step();
        chk("R8 flag in standby", flag_o, 1);
        standby_i = 1'b0; clr_wr_i = 1'b1; step();
        chk("R6 clear after standby", flag_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_and_first();
        t_hold_clear();
        t_mask();
        t_standby();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule